// File: doc/BRIEF.md
# Clock Configuration Two-Wire Block Slave

This block is a two-wire serial slave that holds a small bank of clock-control configuration bytes. A master starts a transfer, addresses the slave with a 7-bit address and a direction bit, and then either writes a block of bytes into the bank or reads the bank back. Each byte travels most significant bit first and is followed by an acknowledge bit. The serial clock and data lines are brought into the system clock domain through two-flop synchronizers. Start, stop and the edges of the serial clock are then detected on the synchronized levels.

On a block write the master sends two framing bytes after the address: a command byte and a count byte. The slave acknowledges both and does not use their contents. Every data byte after them is stored from register byte 0 upward. Bytes past the end of the bank are acknowledged and dropped. On a block read the slave first returns the number of bytes in the bank and then sends the register bytes in order.

Register byte 0 drives the clock-control outputs. Its lowest bit chooses where the frequency-select and spread-enable outputs come from: the hardware strap pins, or bits of the same byte. The data line is open-drain. The slave only ever pulls it low through `sdaLow`.

Top module: `clkCfgSerialSlave`

## Requirements
- R1: After reset, register byte 0 holds 0xA1 and all other bytes hold 0x00. As a result `normalMode`=1, `spreadNarrow`=1, the outputs follow the strap pins, and `sdaLow`=0.
- R2: A falling data line while the clock is high is a start. A rising data line while the clock is high is a stop. Bits are taken MSB first on the rising clock. The slave changes its drive only while the clock is low, except when it releases the line on a start or stop.
- R3: The first byte after a start carries the address in bits 7:1 and the direction in bit 0 (1 = read). If the address does not match, the slave does not acknowledge and ignores all later bytes until the next start.
- R4: On a write, the command byte and the count byte are acknowledged and have no effect. The data bytes that follow are acknowledged and stored into bytes 0, 1, 2 and so on. Configuration outputs change only on a falling serial clock.
- R5: Write data past the last implemented byte (NUM_REGS, default 4) is acknowledged and discarded.
- R6: On a read, the slave sends a count byte equal to NUM_REGS and then bytes 0, 1, and so on. Past the end it sends 0xFF. A master acknowledge asks for the next byte. A master no-acknowledge makes the slave release the line and stop driving.
- R7: With byte 0 bit 0 = 1, `freqSel` equals `pinFreqSel` and `spreadOn` equals `pinSpreadOn`.
- R8: With byte 0 bit 0 = 0, `freqSel` = {bit 4, bit 3} and `spreadOn` = bit 6, and the strap pins have no effect.
- R9: `spreadNarrow` follows byte 0 bit 5 (1 = -0.5%, 0 = -1.0%) and `normalMode` follows bit 7 (0 = test), whatever the value of bit 0.
- R10: A repeated start in the middle of a transfer restarts the byte sequence, so the next written data lands in byte 0. The slave releases the line on a start.
- R11: A stop releases the data line and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-up reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired bus) |
| sdaLow | output | 1 | 1 pulls the data line low, 0 releases it |
| pinFreqSel | input | 2 | Frequency-select strap pins |
| pinSpreadOn | input | 1 | Spread-enable strap pin |
| freqSel | output | 2 | Resolved frequency select |
| spreadOn | output | 1 | Resolved spread enable |
| spreadNarrow | output | 1 | Spread width, 1 = -0.5%, 0 = -1.0% |
| normalMode | output | 1 | 1 = normal operation, 0 = test mode |

## Verification
The hardest situation to reach is a repeated start in the middle of a write. It lands after the command byte has been acknowledged but before any data byte, so the sequencer holds a partial frame when the restart arrives. The bench drives an open-drain bus model: it issues a start, the address and a command byte, then raises the data line and makes a second start without any stop. It then runs a full write frame whose single data byte switches control back to the strap pins. A later read-back shows that the byte landed at position 0 and that byte 1 is unchanged. Overflow and read past the end are reached by writing one more byte than the bank holds and by reading one byte beyond it with a final no-acknowledge.

// File: rtl/clkCfgPkg.sv
package clkCfgPkg;

  // sequencer phases of one transfer
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } seqState_t;

  // strobes from the sequencer to the datapath, one cycle wide
  typedef struct packed {
    logic rxShift;   // take one bit into the receive shifter
    logic ackDrive;  // pull the data line low for an acknowledge
    logic busFree;   // release the data line
    logic txLoadCnt; // start sending the count byte
    logic txLoadReg; // start sending the register byte at the index, then step it
    logic txShift;   // move to the next transmit bit
    logic regWrite;  // store the received byte at the index, then step it
    logic idxClear;  // index back to byte 0
  } strobe_t;

  localparam int BITS_PER_BYTE = 8;
  localparam int ACK_SLOT      = 9;

endpackage

// File: rtl/clkCfgSyncEdge.sv
module clkCfgSyncEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [1:0] lineIn;
  logic [1:0] lineNow;
  logic [1:0] linePrev;

  assign lineIn = {sdaIn, sclIn};

  // identical synchronizer plus history flop for each bus line
  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [STAGES-1:0] pipe;
    logic              prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipe  <= {STAGES{1'b1}};
        prevQ <= 1'b1;
      end else begin
        pipe  <= {pipe[STAGES-2:0], lineIn[g]};
        prevQ <= pipe[STAGES-1];
      end
    end
    assign lineNow[g]  = pipe[STAGES-1];
    assign linePrev[g] = prevQ;
  end

  assign sclLvl    = lineNow[0];
  assign sdaLvl    = lineNow[1];
  assign sclRise   = lineNow[0] & ~linePrev[0];
  assign sclFall   = ~lineNow[0] & linePrev[0];
  assign startSeen = lineNow[0] & linePrev[0] & linePrev[1] & ~lineNow[1];
  assign stopSeen  = lineNow[0] & linePrev[0] & ~linePrev[1] & lineNow[1];

endmodule

// File: rtl/clkCfgSeqCtrl.sv
module clkCfgSeqCtrl
  import clkCfgPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sdaLvl,
  input  logic [7:0] rxByte,
  output strobe_t    stb
);

  seqState_t  state, stateNext;
  logic [3:0] bitCnt, bitCntNext;
  logic       isRead, isReadNext;
  logic       mNack, mNackNext;
  logic       rxState;
  logic       addrHit;

  assign rxState = (state == ST_ADDR) || (state == ST_CMD) ||
                   (state == ST_CNT)  || (state == ST_WDATA);
  assign addrHit = (rxByte[7:1] == DEV_ADDR);

  always_comb begin
    stb        = '0;
    stateNext  = state;
    bitCntNext = bitCnt;
    isReadNext = isRead;
    mNackNext  = mNack;
    if (startSeen) begin
      stateNext    = ST_ADDR;
      bitCntNext   = '0;
      stb.busFree  = 1'b1;
      stb.idxClear = 1'b1;
    end else if (stopSeen) begin
      stateNext   = ST_IDLE;
      bitCntNext  = '0;
      stb.busFree = 1'b1;
    end else if (state == ST_IDLE || state == ST_SKIP) begin
      stateNext = state;
    end else if (sclRise) begin
      if (rxState && bitCnt < 4'(BITS_PER_BYTE)) stb.rxShift = 1'b1;
      if (state == ST_RDATA && bitCnt == 4'(BITS_PER_BYTE)) mNackNext = sdaLvl;
      if (bitCnt < 4'(ACK_SLOT)) bitCntNext = bitCnt + 4'd1;
    end else if (sclFall) begin
      if (bitCnt == 4'(BITS_PER_BYTE)) begin
        // byte complete: open the acknowledge slot
        case (state)
          ST_ADDR: begin
            if (addrHit) begin
              stb.ackDrive = 1'b1;
              isReadNext   = rxByte[0];
            end else begin
              stateNext = ST_SKIP;
            end
          end
          ST_CMD, ST_CNT: stb.ackDrive = 1'b1;
          ST_WDATA: begin
            stb.ackDrive = 1'b1;
            stb.regWrite = 1'b1;
          end
          default: stb.busFree = 1'b1;
        endcase
      end else if (bitCnt == 4'(ACK_SLOT)) begin
        // acknowledge slot over: advance to the next byte
        bitCntNext = '0;
        case (state)
          ST_ADDR: begin
            if (isRead) begin
              stateNext     = ST_RDATA;
              stb.txLoadCnt = 1'b1;
            end else begin
              stateNext   = ST_CMD;
              stb.busFree = 1'b1;
            end
          end
          ST_CMD: begin
            stateNext   = ST_CNT;
            stb.busFree = 1'b1;
          end
          ST_CNT: begin
            stateNext   = ST_WDATA;
            stb.busFree = 1'b1;
          end
          ST_RDATA: begin
            if (mNack) begin
              stateNext   = ST_SKIP;
              stb.busFree = 1'b1;
            end else begin
              stb.txLoadReg = 1'b1;
            end
          end
          default: stb.busFree = 1'b1;
        endcase
      end else if (state == ST_RDATA && bitCnt != 4'd0) begin
        stb.txShift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
      mNack  <= 1'b0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
      isRead <= isReadNext;
      mNack  <= mNackNext;
    end
  end

endmodule

// File: rtl/clkCfgDatapath.sv
module clkCfgDatapath
  import clkCfgPkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter logic [7:0] INIT0    = 8'hA1
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic       sdaLvl,
  input  logic [1:0] pinFreqSel,
  input  logic       pinSpreadOn,
  output logic [7:0] rxByte,
  output logic       sdaLow,
  output logic [1:0] freqSel,
  output logic       spreadOn,
  output logic       spreadNarrow,
  output logic       normalMode
);

  localparam int                IDX_W    = $clog2(NUM_REGS + 1);
  localparam int                ADDR_W   = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0]  IDX_END  = IDX_W'(NUM_REGS);
  localparam logic [7:0]        CNT_BYTE = 8'(NUM_REGS);

  logic [7:0]       regView [NUM_REGS];
  logic [IDX_W-1:0] idx;
  logic [7:0]       txShiftQ;
  logic             ackOn;
  logic             txOn;
  logic             idxValid;
  logic [7:0]       txPick;

  assign idxValid = (idx < IDX_END);
  assign txPick   = idxValid ? regView[idx[ADDR_W-1:0]] : 8'hFF;

  // one configuration byte per position, byte 0 with its own power-up value
  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    localparam logic [7:0] RST_VAL = (r == 0) ? INIT0 : 8'h00;
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= RST_VAL;
      else if (stb.regWrite && idx == IDX_W'(r)) q <= rxByte;
    end
    assign regView[r] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      idx      <= '0;
      txShiftQ <= 8'hFF;
      ackOn    <= 1'b0;
      txOn     <= 1'b0;
    end else begin
      if (stb.rxShift) rxByte <= {rxByte[6:0], sdaLvl};
      if (stb.idxClear) idx <= '0;
      else if ((stb.regWrite || stb.txLoadReg) && idx != IDX_END) idx <= idx + 1'b1;
      if (stb.busFree) begin
        ackOn <= 1'b0;
        txOn  <= 1'b0;
      end else if (stb.ackDrive) begin
        ackOn <= 1'b1;
        txOn  <= 1'b0;
      end else if (stb.txLoadCnt) begin
        txShiftQ <= CNT_BYTE;
        txOn     <= 1'b1;
        ackOn    <= 1'b0;
      end else if (stb.txLoadReg) begin
        txShiftQ <= txPick;
        txOn     <= 1'b1;
        ackOn    <= 1'b0;
      end else if (stb.txShift) begin
        txShiftQ <= {txShiftQ[6:0], 1'b1};
      end
    end
  end

  assign sdaLow = ackOn | (txOn & ~txShiftQ[7]);

  // control source choice: bit 0 of byte 0
  assign freqSel      = regView[0][0] ? pinFreqSel  : {regView[0][4], regView[0][3]};
  assign spreadOn     = regView[0][0] ? pinSpreadOn : regView[0][6];
  assign spreadNarrow = regView[0][5];
  assign normalMode   = regView[0][7];

endmodule

// File: rtl/clkCfgSerialSlave.sv
module clkCfgSerialSlave
  import clkCfgPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 4,
  parameter logic [7:0] INIT0       = 8'hA1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaLow,
  input  logic [1:0] pinFreqSel,
  input  logic       pinSpreadOn,
  output logic [1:0] freqSel,
  output logic       spreadOn,
  output logic       spreadNarrow,
  output logic       normalMode
);

  logic       sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic [7:0] rxByte;
  strobe_t    stb;

  clkCfgSyncEdge #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  clkCfgSeqCtrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .stb(stb)
  );

  clkCfgDatapath #(.NUM_REGS(NUM_REGS), .INIT0(INIT0)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(sdaLvl),
    .pinFreqSel(pinFreqSel), .pinSpreadOn(pinSpreadOn),
    .rxByte(rxByte), .sdaLow(sdaLow), .freqSel(freqSel),
    .spreadOn(spreadOn), .spreadNarrow(spreadNarrow), .normalMode(normalMode)
  );

endmodule

// File: rtl/clkCfgSerialSlaveChk.sv
module clkCfgSerialSlaveChk (
  input logic clk,
  input logic rstN,
  input logic sclLvl,
  input logic sclFall,
  input logic startSeen,
  input logic stopSeen,
  input logic sdaLow,
  input logic spreadNarrow,
  input logic normalMode
);

  // R2: drive changes only while the clock is low, apart from start/stop release
  p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($changed(sdaLow) && !$past(startSeen) && !$past(stopSeen)) |-> !$past(sclLvl));

  // R10: a start leaves the line released
  p_free_on_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaLow);

  // R11: a stop leaves the line released
  p_free_on_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaLow);

  // R4: configuration bits move only right after a falling serial clock
  p_cfg_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($changed(normalMode) || $changed(spreadNarrow)) |-> $past(sclFall));

endmodule

bind clkCfgSerialSlave clkCfgSerialSlaveChk uChk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sclFall(sclFall),
  .startSeen(startSeen), .stopSeen(stopSeen), .sdaLow(sdaLow),
  .spreadNarrow(spreadNarrow), .normalMode(normalMode)
);

// File: tb/clkCfgSerialSlave_test.sv
`timescale 1ns/1ps
module clkCfgSerialSlave_test;

  localparam int Q = 8;
  localparam logic [7:0] ADDR_W = 8'hD2;
  localparam logic [7:0] ADDR_R = 8'hD3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic       sdaLow;
  logic       sdaBus;
  logic [1:0] pinFreqSel = 2'b10;
  logic       pinSpreadOn = 1'b1;
  logic [1:0] freqSel;
  logic       spreadOn, spreadNarrow, normalMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    expQ[$];
  string tagQ[$];
  int    obsVal;
  event  obsEv;

  always #2 clk = ~clk;
  assign sdaBus = mSda & ~sdaLow;

  clkCfgSerialSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaLow(sdaLow),
    .pinFreqSel(pinFreqSel), .pinSpreadOn(pinSpreadOn), .freqSel(freqSel),
    .spreadOn(spreadOn), .spreadNarrow(spreadNarrow), .normalMode(normalMode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pairs each observed bus item with the oldest expectation
  initial forever begin
    @(obsEv);
    if (expQ.size() == 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard act=%0h exp=none", obsVal);
    end else begin
      string t;
      int e;
      t = tagQ.pop_front();
      e = expQ.pop_front();
      check(t, obsVal, e);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input int expAck, input string tag);
    expQ.push_back(expAck);
    tagQ.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(Q);
      mScl = 1'b1; tick(2 * Q);
      mScl = 1'b0; tick(Q);
    end
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    obsVal = int'(!sdaBus);
    -> obsEv;
    tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic readByte(input int expVal, input bit ackIt, input string tag);
    logic [7:0] v;
    expQ.push_back(expVal);
    tagQ.push_back(tag);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      mScl = 1'b1; tick(Q);
      v[i] = sdaBus; tick(Q);
      mScl = 1'b0; tick(Q);
    end
    obsVal = int'(v);
    -> obsEv;
    mSda = ackIt ? 1'b0 : 1'b1; tick(Q);
    mScl = 1'b1; tick(2 * Q);
    mScl = 1'b0; tick(Q);
    mSda = 1'b1;
  endtask

  task automatic checkOuts(input string tag, input int f, input int s, input int n, input int m);
    check({tag, " freqSel"}, int'(freqSel), f);
    check({tag, " spreadOn"}, int'(spreadOn), s);
    check({tag, " spreadNarrow"}, int'(spreadNarrow), n);
    check({tag, " normalMode"}, int'(normalMode), m);
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(5);
    // R1: power-up byte 0 = 0xA1, pins drive the controls
    checkOuts("R1 reset", 2, 1, 1, 1);
    check("R1 sdaLow idle", int'(sdaLow), 0);

    // R3: foreign address gets no acknowledge, later bytes ignored
    busStart();
    sendByte(8'h44, 0, "R3 foreign addr ack");
    sendByte(8'h00, 0, "R3 ignored byte ack");
    busStop();
    checkOuts("R3 unchanged", 2, 1, 1, 1);

    // R4/R5: block write, one byte past the end
    busStart();
    sendByte(ADDR_W, 1, "R3 addr ack");
    sendByte(8'h5A, 1, "R4 cmd ack");
    sendByte(8'h77, 1, "R4 count ack");
    sendByte(8'h98, 1, "R4 data0 ack");
    sendByte(8'h11, 1, "R4 data1 ack");
    sendByte(8'h22, 1, "R4 data2 ack");
    sendByte(8'h33, 1, "R4 data3 ack");
    sendByte(8'h44, 1, "R5 overflow ack");
    busStop();
    tick(4);
    check("R11 released after stop", int'(sdaLow), 0);
    // R8/R9: byte0 = 0x98 -> freq 3, spread off, width 1.0%, normal
    checkOuts("R8 register source", 3, 0, 0, 1);
    pinFreqSel = 2'b01; pinSpreadOn = 1'b0;
    tick(4);
    checkOuts("R8 pins ignored", 3, 0, 0, 1);

    // R6: block read with a byte past the end, last byte not acknowledged
    busStart();
    sendByte(ADDR_R, 1, "R6 read addr ack");
    readByte(4, 1, "R6 count byte");
    readByte(8'h98, 1, "R6 byte0");
    readByte(8'h11, 1, "R6 byte1");
    readByte(8'h22, 1, "R6 byte2");
    readByte(8'h33, 1, "R5 byte3 kept");
    readByte(8'hFF, 0, "R6 past end");
    tick(4);
    check("R6 released after nack", int'(sdaLow), 0);
    busStop();

    // R9: byte0 = 0x40 -> test mode, spread on, freq 0
    busStart();
    sendByte(ADDR_W, 1, "R3 addr ack 2");
    sendByte(8'h00, 1, "R4 cmd ack 2");
    sendByte(8'h01, 1, "R4 count ack 2");
    sendByte(8'h40, 1, "R4 data ack 2");
    busStop();
    checkOuts("R9 test mode", 0, 1, 0, 0);

    // R10: repeated start after the command byte, then a fresh frame
    busStart();
    sendByte(ADDR_W, 1, "R10 addr ack a");
    sendByte(8'h00, 1, "R10 cmd ack a");
    busStart();
    tick(2);
    check("R10 released on start", int'(sdaLow), 0);
    sendByte(ADDR_W, 1, "R10 addr ack b");
    sendByte(8'h00, 1, "R10 cmd ack b");
    sendByte(8'h01, 1, "R10 count ack b");
    sendByte(8'h61, 1, "R10 data ack b");
    busStop();
    // R7: byte0 = 0x61 -> pins (01, 0), width 0.5%, test mode
    checkOuts("R7 pin source", 1, 0, 1, 0);
    pinFreqSel = 2'b11; pinSpreadOn = 1'b1;
    tick(4);
    checkOuts("R7 pins follow", 3, 1, 1, 0);

    busStart();
    sendByte(ADDR_R, 1, "R10 read addr ack");
    readByte(4, 1, "R10 count byte");
    readByte(8'h61, 1, "R10 byte0 landed");
    readByte(8'h11, 0, "R10 byte1 intact");
    busStop();

    tick(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule